// File: doc/BRIEF.md
# SPI Frame Timing Generator

This block produces the serial clock and the chip-select timing for one SPI frame at a time. A start pulse captures a 31-bit attribute word and a continue flag. The attribute word holds the frame length, the clock polarity and phase, the bit order, and two-stage dividers for the bit rate and for three delays. The three delays are select-to-first-edge (lead), last-edge-to-release (trail) and the quiet time between frames (gap). The block does not move any data. A shift strobe marks the first cycle of every bit period, and a separate data path uses it to present or capture bits.

Each divider is the product of a prescaler and a scaler. For the bit rate the prescaler picks from {2, 3, 5, 7}. The scaler picks from 2, 4, 6 and 8, and above those from powers of two up to 32768. For the delays the prescaler picks from {1, 3, 5, 7} and the scaler is 2^(j+1). When the continue flag is set, chip select stays asserted after the frame, so several frames can run back to back under one selection.

Top module: `spi_frame_timer`

## Requirements
- R1: While reset is high and after its release, sck_o, cs_en_o, shift_o, busy_o and lsb_first_o are all 0.
- R2: A start_i pulse seen while busy_o is low makes busy_o high from the next cycle. busy_o then stays high for exactly Dlead + N*P + Dtrail + Dgap cycles.
- R3: With the continue flag clear, cs_en_o rises in the same cycle as busy_o. It stays high for Dlead + N*P + Dtrail cycles and then drops for the gap.
- R4: With the continue flag set, cs_en_o stays high through the gap and while idle, until a later frame started with the flag clear releases it.
- R5: The bit period is P = B * S system clocks. B is {2,3,5,7}, chosen by attribute bits 17:16. S is chosen by bits 3:0: codes 0..3 give 2,4,6,8 and code k >= 4 gives 2^k. SCK stays for P/2 cycles in each level.
- R6: Each delay lasts (2c+1) * 2^(j+1) cycles. Lead uses c from bits 23:22 and j from bits 15:12. Trail uses bits 21:20 and 11:8. Gap uses bits 19:18 and 7:4.
- R7: Bits 30:27 hold N-1, giving frames of 4 to 16 bits. Codes 0, 1 and 2 are treated as 4 bits. A frame has N shift pulses and 2N SCK edges.
- R8: Outside the bit phase, sck_o sits at the level of attribute bit 26 (polarity). This holds from the first busy cycle of a frame until its next frame starts.
- R9: Attribute bit 25 (phase) sets the first SCK edge. With phase 0 it comes P/2 cycles after the lead delay ends. With phase 1 it comes in the first cycle after the lead delay.
- R10: shift_o is a one-cycle pulse in the first cycle of each bit period. The first pulse comes Dlead cycles after busy_o rises.
- R11: A start_i pulse while busy_o is high is ignored. It neither restarts nor changes the running frame, and it does not queue a later one.
- R12: lsb_first_o shows attribute bit 24 captured at the start pulse and holds it after the frame ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a frame (used only when idle) |
| attr_i | input | 31 | Attribute word for the frame |
| cont_i | input | 1 | Keep chip select asserted after the frame |
| sck_o | output | 1 | Serial clock |
| cs_en_o | output | 1 | Chip-select enable, active high |
| shift_o | output | 1 | One-cycle pulse at the start of each bit |
| busy_o | output | 1 | Frame in progress, gap included |
| lsb_first_o | output | 1 | Captured bit-order selection |

## Verification
The bench builds the block with its default counter width of 20 bits. This width holds the longest delay of 458752 cycles, so every prescaler and scaler code is legal. The bench picks codes that keep each frame short and still cover all four bit-rate prescalers. It also covers the first scaler above the linear range, the clamped short-frame codes, 16-bit frames, and both polarities and phases. Other cases are a continued frame followed by a releasing one, and a second start during a running frame.

// File: rtl/spi_ft_pkg.sv
package spi_ft_pkg;

    localparam int ATTR_W = 31;
    localparam int FSZ_W  = 4;
    localparam int NB_W   = FSZ_W + 1;
    localparam int HC_W   = NB_W + 1;
    localparam int NDLY   = 3;
    localparam int MIN_BITS = 4;

    // Field layout is significant: software composes the word by position.
    typedef struct packed {
        logic [FSZ_W-1:0] fsize_m1;   // 30:27
        logic             cpol;       // 26
        logic             cpha;       // 25
        logic             lsb_first;  // 24
        logic [1:0]       lead_pre;   // 23:22
        logic [1:0]       trail_pre;  // 21:20
        logic [1:0]       gap_pre;    // 19:18
        logic [1:0]       baud_pre;   // 17:16
        logic [3:0]       lead_scl;   // 15:12
        logic [3:0]       trail_scl;  // 11:8
        logic [3:0]       gap_scl;    // 7:4
        logic [3:0]       baud_scl;   // 3:0
    } attr_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_LEAD, PH_BITS, PH_TRAIL, PH_GAP
    } phase_e;

    function automatic logic [2:0] baud_pre_val(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd2;
            2'd1:    return 3'd3;
            2'd2:    return 3'd5;
            default: return 3'd7;
        endcase
    endfunction

    // Half of the bit-rate scaler (scaler is always even).
    function automatic logic [15:0] baud_half_scl(input logic [3:0] code);
        if (code < 4'd4) return 16'(code) + 16'd1;
        return 16'd1 << (code - 4'd1);
    endfunction

    function automatic logic [2:0] dly_pre_val(input logic [1:0] code);
        return {code, 1'b1};
    endfunction

    function automatic logic [16:0] dly_scl_val(input logic [3:0] code);
        return 17'd2 << code;
    endfunction

    function automatic logic [NB_W-1:0] frame_bits(input logic [FSZ_W-1:0] code);
        if (code < FSZ_W'(MIN_BITS - 1)) return NB_W'(MIN_BITS);
        return {1'b0, code} + NB_W'(1);
    endfunction

endpackage

// File: rtl/spi_ft_baud_dec.sv
module spi_ft_baud_dec #(
    parameter int CNT_W = 20
) (
    input  logic [1:0]       pre_i,
    input  logic [3:0]       scl_i,
    output logic [CNT_W-1:0] half_o
);
    import spi_ft_pkg::*;

    always_comb begin
        half_o = CNT_W'(baud_pre_val(pre_i)) * CNT_W'(baud_half_scl(scl_i));
    end

endmodule

// File: rtl/spi_ft_dly_dec.sv
module spi_ft_dly_dec #(
    parameter int CNT_W = 20
) (
    input  logic [1:0]       pre_i,
    input  logic [3:0]       scl_i,
    output logic [CNT_W-1:0] cyc_o
);
    import spi_ft_pkg::*;

    always_comb begin
        cyc_o = CNT_W'(dly_pre_val(pre_i)) * CNT_W'(dly_scl_val(scl_i));
    end

endmodule

// File: rtl/spi_ft_downcnt.sv
module spi_ft_downcnt #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);
    always_ff @(posedge clk) begin
        if (rst)              cnt_o <= '0;
        else if (load_i)      cnt_o <= val_i;
        else if (cnt_o != '0) cnt_o <= cnt_o - W'(1);
    end

    assign zero_o = (cnt_o == '0);

endmodule

// File: rtl/spi_frame_timer.sv
module spi_frame_timer #(
    parameter int CNT_W = 20
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic [spi_ft_pkg::ATTR_W-1:0] attr_i,
    input  logic                          cont_i,
    output logic                          sck_o,
    output logic                          cs_en_o,
    output logic                          shift_o,
    output logic                          busy_o,
    output logic                          lsb_first_o
);
    import spi_ft_pkg::*;

    localparam int LEAD = 0;
    localparam int TRAIL = 1;
    localparam int GAP = 2;

    phase_e            phase_q, phase_n;
    attr_t             cfg_q, cfg_sel;
    logic              cont_q;
    logic              cs_q;
    logic [HC_W-1:0]   half_idx_q;
    logic [HC_W-1:0]   last_half;
    logic              accept;

    logic              ld;
    logic [CNT_W-1:0]  ld_val;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_zero;

    logic [CNT_W-1:0]  half_cyc;
    logic [1:0]        dly_pre [NDLY];
    logic [3:0]        dly_scl [NDLY];
    logic [CNT_W-1:0]  dly_cyc [NDLY];

    assign accept  = (phase_q == PH_IDLE) && start_i;
    // Decoders see the incoming word in the start cycle, the held word after.
    assign cfg_sel = accept ? attr_t'(attr_i) : cfg_q;

    assign dly_pre[LEAD]  = cfg_sel.lead_pre;
    assign dly_scl[LEAD]  = cfg_sel.lead_scl;
    assign dly_pre[TRAIL] = cfg_sel.trail_pre;
    assign dly_scl[TRAIL] = cfg_sel.trail_scl;
    assign dly_pre[GAP]   = cfg_sel.gap_pre;
    assign dly_scl[GAP]   = cfg_sel.gap_scl;

    generate
        for (genvar k = 0; k < NDLY; k++) begin : g_dly
            spi_ft_dly_dec #(.CNT_W(CNT_W)) u_dly (
                .pre_i (dly_pre[k]),
                .scl_i (dly_scl[k]),
                .cyc_o (dly_cyc[k])
            );
        end
    endgenerate

    spi_ft_baud_dec #(.CNT_W(CNT_W)) u_baud (
        .pre_i  (cfg_sel.baud_pre),
        .scl_i  (cfg_sel.baud_scl),
        .half_o (half_cyc)
    );

    spi_ft_downcnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load_i (ld),
        .val_i  (ld_val),
        .cnt_o  (cnt),
        .zero_o (cnt_zero)
    );

    assign last_half = {frame_bits(cfg_q.fsize_m1), 1'b0} - HC_W'(1);

    always_comb begin
        phase_n = phase_q;
        ld      = 1'b0;
        ld_val  = '0;
        case (phase_q)
            PH_IDLE: if (start_i) begin
                phase_n = PH_LEAD;
                ld      = 1'b1;
                ld_val  = dly_cyc[LEAD] - CNT_W'(1);
            end
            PH_LEAD: if (cnt_zero) begin
                phase_n = PH_BITS;
                ld      = 1'b1;
                ld_val  = half_cyc - CNT_W'(1);
            end
            PH_BITS: if (cnt_zero) begin
                ld = 1'b1;
                if (half_idx_q == last_half) begin
                    phase_n = PH_TRAIL;
                    ld_val  = dly_cyc[TRAIL] - CNT_W'(1);
                end else begin
                    ld_val  = half_cyc - CNT_W'(1);
                end
            end
            PH_TRAIL: if (cnt_zero) begin
                phase_n = PH_GAP;
                ld      = 1'b1;
                ld_val  = dly_cyc[GAP] - CNT_W'(1);
            end
            PH_GAP: if (cnt_zero) phase_n = PH_IDLE;
            default: phase_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            cfg_q      <= '0;
            cont_q     <= 1'b0;
            cs_q       <= 1'b0;
            half_idx_q <= '0;
        end else begin
            phase_q <= phase_n;
            if (accept) begin
                cfg_q  <= attr_t'(attr_i);
                cont_q <= cont_i;
                cs_q   <= 1'b1;
            end
            if (phase_q == PH_LEAD)
                half_idx_q <= '0;
            else if (phase_q == PH_BITS && cnt_zero)
                half_idx_q <= half_idx_q + HC_W'(1);
            if (phase_q == PH_TRAIL && cnt_zero && !cont_q)
                cs_q <= 1'b0;
        end
    end

    // Even half-periods sit at idle level when phase is 0, active when 1.
    assign sck_o       = (phase_q == PH_BITS) ? (cfg_q.cpol ^ cfg_q.cpha ^ half_idx_q[0])
                                              : cfg_q.cpol;
    assign shift_o     = (phase_q == PH_BITS) && !half_idx_q[0] && (cnt == half_cyc - CNT_W'(1));
    assign busy_o      = (phase_q != PH_IDLE);
    assign cs_en_o     = cs_q;
    assign lsb_first_o = cfg_q.lsb_first;

    p_start_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && cs_en_o));

    p_shift_inside_r10: assert property (@(posedge clk) disable iff (rst)
        shift_o |-> (cs_en_o && busy_o));

    p_shift_single_r10: assert property (@(posedge clk) disable iff (rst)
        shift_o |=> !shift_o);

    p_sck_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !cs_en_o |-> $stable(sck_o));

    p_cs_release_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_en_o) |-> (busy_o && !shift_o && (sck_o == cfg_q.cpol)));

    p_ignore_start_r11: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(lsb_first_o));

endmodule

// File: tb/spi_frame_timer_tb.sv
`timescale 1ns/1ps
module spi_frame_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [30:0] attr_i = '0;
    logic        cont_i = 1'b0;
    logic        sck_o, cs_en_o, shift_o, busy_o, lsb_first_o;

    int nchk = 0;
    int nfail = 0;
    int frames_seen = 0;
    int frames_sent = 0;

    typedef struct {
        int busy_len; int cs_len; int first_shift; int n_shift;
        int first_sck; int n_tog; int half; int cpol; int lsb; int cont;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    spi_frame_timer u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .attr_i(attr_i), .cont_i(cont_i),
        .sck_o(sck_o), .cs_en_o(cs_en_o), .shift_o(shift_o), .busy_o(busy_o),
        .lsb_first_o(lsb_first_o)
    );

    task automatic chk(input string req, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [30:0] mk(input int fsz, input int cpol, input int cpha, input int lsb,
        input int lp, input int ls, input int tp, input int ts,
        input int gp, input int gs, input int bp, input int bs);
        logic [30:0] a;
        a = '0;
        a[30:27] = 4'(fsz); a[26] = 1'(cpol); a[25] = 1'(cpha); a[24] = 1'(lsb);
        a[23:22] = 2'(lp); a[21:20] = 2'(tp); a[19:18] = 2'(gp); a[17:16] = 2'(bp);
        a[15:12] = 4'(ls); a[11:8] = 4'(ts); a[7:4] = 4'(gs); a[3:0] = 4'(bs);
        return a;
    endfunction

    function automatic int dly(input int c, input int j);
        return (2 * c + 1) * (2 << j);
    endfunction

    function automatic int baud(input int b, input int s);
        int pre;
        case (b) 0: pre = 2; 1: pre = 3; 2: pre = 5; default: pre = 7; endcase
        return pre * ((s < 4) ? 2 * (s + 1) : (1 << s));
    endfunction

    function automatic exp_t predict(input logic [30:0] a, input int cont);
        exp_t e;
        int n, p, dl, dt, dg;
        n  = (a[30:27] < 3) ? 4 : int'(a[30:27]) + 1;
        p  = baud(int'(a[17:16]), int'(a[3:0]));
        dl = dly(int'(a[23:22]), int'(a[15:12]));
        dt = dly(int'(a[21:20]), int'(a[11:8]));
        dg = dly(int'(a[19:18]), int'(a[7:4]));
        e.busy_len    = dl + n * p + dt + dg;
        e.cs_len      = cont ? e.busy_len : dl + n * p + dt;
        e.first_shift = dl;
        e.n_shift     = n;
        e.first_sck   = a[25] ? dl : dl + p / 2;
        e.n_tog       = 2 * n;
        e.half        = p / 2;
        e.cpol        = int'(a[26]);
        e.lsb         = int'(a[24]);
        e.cont        = cont;
        return e;
    endfunction

    task automatic run_frame(input logic [30:0] a, input int cont, input int extra);
        while (busy_o) @(negedge clk);
        q.push_back(predict(a, cont));
        frames_sent++;
        attr_i = a; cont_i = 1'(cont); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; attr_i = ~a; cont_i = ~1'(cont);
        if (extra != 0) begin
            repeat (3) @(negedge clk);
            attr_i = mk(15, 1, 1, ~a[24], 3, 9, 3, 9, 3, 9, 3, 9);   // R11 intruder
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor / scoreboard
    initial begin : mon
        forever begin
            @(negedge clk);
            if (!rst && busy_o) begin
                exp_t e;
                int idx, fshift, nshift, fsck, ntog, t1, t2, cslen;
                logic psck;
                idx = 0; fshift = -1; nshift = 0; fsck = -1; ntog = 0; t1 = -1; t2 = -1; cslen = 0;
                if (q.size() == 0) begin
                    nchk++; nfail++;
                    $display("FAIL R11 unexpected frame actual=%0d expected=%0d", frames_seen + 1, frames_sent);
                    e = predict('0, 0);
                end else begin
                    e = q.pop_front();
                end
                chk("R8 sck at idle level at frame begin", int'(sck_o), e.cpol);
                chk("R3 cs asserted with busy", int'(cs_en_o), 1);
                psck = sck_o;
                while (busy_o) begin
                    if (cs_en_o) cslen++;
                    if (shift_o) begin
                        nshift++;
                        if (fshift < 0) fshift = idx;
                    end
                    if (fsck < 0 && int'(sck_o) != e.cpol) fsck = idx;
                    if (idx > 0 && sck_o != psck) begin
                        ntog++;
                        if (t1 < 0) t1 = idx; else if (t2 < 0) t2 = idx;
                    end
                    psck = sck_o;
                    idx++;
                    @(negedge clk);
                end
                frames_seen++;
                chk("R2 busy length", idx, e.busy_len);
                chk("R3 cs length within frame", cslen, e.cs_len);
                chk("R10 first shift offset", fshift, e.first_shift);
                chk("R7 shift pulse count", nshift, e.n_shift);
                chk("R9 first sck edge offset", fsck, e.first_sck);
                chk("R7 sck edge count", ntog, e.n_tog);
                chk("R5 sck half period", t2 - t1, e.half);
                chk("R4 cs level after frame", int'(cs_en_o), e.cont);
                chk("R8 sck idle after frame", int'(sck_o), e.cpol);
                chk("R12 bit order held", int'(lsb_first_o), e.lsb);
            end
        end
    end

    initial begin : wdog
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", frames_seen, frames_sent);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin : drv
        repeat (4) @(negedge clk);
        chk("R1 sck in reset", int'(sck_o), 0);
        chk("R1 cs in reset", int'(cs_en_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy_o), 0);
        chk("R1 shift after reset", int'(shift_o), 0);
        chk("R1 lsb after reset", int'(lsb_first_o), 0);
        chk("R1 cs after reset", int'(cs_en_o), 0);
        // R5 R6 R7: 8-bit, fastest bit rate
        run_frame(mk(7, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0), 0, 0);
        // R9 R12: 16-bit, polarity 1 phase 1, lsb first
        run_frame(mk(15, 1, 1, 1, 2, 2, 0, 0, 3, 0, 1, 1), 0, 0);
        // R4 R7: clamped 4-bit, scaler code 4, continue set
        run_frame(mk(1, 0, 1, 0, 0, 1, 0, 1, 0, 0, 3, 4), 1, 0);
        chk("R4 cs held while idle", int'(cs_en_o), 1);
        // R4 release, R6 larger delays
        run_frame(mk(4, 1, 0, 1, 3, 3, 1, 1, 2, 0, 2, 2), 0, 0);
        chk("R4 cs released while idle", int'(cs_en_o), 0);
        // R11: second start during a running frame
        run_frame(mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1), 0, 1);
        // R7 code 0 clamp with phase 1
        run_frame(mk(0, 1, 1, 0, 1, 3, 0, 0, 0, 0, 1, 0), 0, 0);
        repeat (20) @(negedge clk);
        chk("R11 frame count", frames_seen, frames_sent);
        chk("R11 no pending expectations", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule